// File: doc/BRIEF.md
# Banked Message-Signalled Interrupt Receiver

This block sits behind the inbound side of a PCIe root port and turns memory-write messages into interrupt vectors. Each message presents a 64-bit address and a 32-bit data word. When the address equals a programmed 64-bit target, the data word is taken as the vector number. If that vector is in range and enabled, its pending bit is set.

Vectors are held in banks of 32. Each bank has an enable word, a mask word and a pending-status word. Pending bits are cleared by writing ones to them. One level-sensitive interrupt output summarises every bank: it is high while any pending vector is not masked. Software then reads each bank's status word to find the vectors that need service.

Top module: `msi_vector_rx`

## Requirements
- R1: After reset, every pending bit is 0, every mask bit is 1, every enable bit is 0, both target words are 0, the interrupt output is 0, and read data is 0.
- R2: Register word 0 holds the low 32 bits of the target address and word 1 holds the high 32 bits. Both can be written and read back.
- R3: A message with msg_valid high sets pending bit N at the next clock edge when all of these hold: its full 64-bit address equals {word 1, word 0}, its data N is below NUM_VEC, and enable bit N is 1.
- R4: A message whose address differs from the target in either half changes no pending bit.
- R5: A message whose vector number is NUM_VEC or above, or whose vector's enable bit is 0, is dropped and changes no pending bit.
- R6: A write to a status word clears exactly the bits written as 1. Bits written as 0 keep their value.
- R7: irq_out is high one cycle after any bank holds a pending bit whose mask bit is 0, and is low otherwise.
- R8: A message for a masked vector still sets its pending bit. Clearing the mask bit later raises irq_out.
- R9: When a message sets a pending bit in the same cycle that a status write clears that bit, the bit ends up set. Other bits named in the same write are cleared.
- R10: Register words are mapped as follows: bank b uses word 4+4b for enable, 5+4b for mask and 6+4b for status. A read returns the addressed word on the cycle after reg_re, and returns 0 when reg_re is low or the word is unmapped. Writes to unmapped words have no effect.
- R11: Vector N belongs to bank N/32 at bit position N%32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_valid | input | 1 | Inbound message strobe |
| msg_addr | input | 64 | Message write address |
| msg_data | input | 32 | Message data (vector number) |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | RA_W | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Summary interrupt, level |

## Verification
A message that sets a pending bit and a software write-one-to-clear on the same status word can both land in the same cycle. The bench provokes this by driving a message for one vector together with a status write whose data names that vector and a neighbouring pending vector. The expected result is that the message's bit survives and the neighbour is cleared. A behavioural model replays every cycle, so the following read-back and the irq_out level are each judged against it, and enable and mask writes that coincide with messages are judged the same way.

// File: rtl/msi_rx_pkg.sv
package msi_rx_pkg;
  localparam int BANK_VEC = 32;
  localparam int BANK_STRIDE = 4;
  localparam int BANK_BASE = 4;

  typedef enum logic [1:0] {
    SEL_EN   = 2'd0,
    SEL_MASK = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } bank_sel_e;
endpackage

// File: rtl/msi_msg_decode.sv
module msi_msg_decode #(
  parameter int NUM_VEC = 64,
  parameter int HIT_W   = 64
) (
  input  logic              msg_valid,
  input  logic [63:0]       msg_addr,
  input  logic [31:0]       msg_data,
  input  logic [63:0]       target,
  output logic [HIT_W-1:0]  hit_vec
);
  localparam int IDX_W = (HIT_W > 1) ? $clog2(HIT_W) : 1;

  logic addr_ok;
  logic range_ok;

  assign addr_ok  = (msg_addr == target);
  assign range_ok = (msg_data < 32'(NUM_VEC));

  always_comb begin
    hit_vec = '0;
    if (msg_valid && addr_ok && range_ok)
      hit_vec[msg_data[IDX_W-1:0]] = 1'b1;
  end
endmodule

// File: rtl/msi_bank.sv
module msi_bank #(
  parameter int BW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [BW-1:0] set_vec,
  input  logic          wr_en,
  input  logic          wr_mask,
  input  logic          wr_stat,
  input  logic [BW-1:0] wdata,
  output logic [BW-1:0] en_q,
  output logic [BW-1:0] mask_q,
  output logic [BW-1:0] stat_q,
  output logic          pend
);
  logic [BW-1:0] clr_bits;
  logic [BW-1:0] set_bits;

  assign clr_bits = wr_stat ? wdata : '0;
  assign set_bits = set_vec & en_q;
  assign pend     = |(stat_q & ~mask_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      mask_q <= '1;
      stat_q <= '0;
    end else begin
      if (wr_en)   en_q   <= wdata;
      if (wr_mask) mask_q <= wdata;
      // set has priority over a simultaneous clear (R9)
      stat_q <= (stat_q & ~clr_bits) | set_bits;
    end
  end

  // a pending bit may only fall where software wrote a one
  assert_w1c_only_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(stat_q) & ~stat_q) & ~($past(wr_stat) ? $past(wdata) : {BW{1'b0}})) == {BW{1'b0}}));

  // a pending bit may only rise for a delivered, enabled vector
  assert_set_needs_enable_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((stat_q & ~$past(stat_q)) & ~($past(set_vec) & $past(en_q))) == {BW{1'b0}}));

  // a delivered, enabled vector is pending on the next cycle
  assert_set_lands_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(set_vec) & $past(en_q)) & ~stat_q) == {BW{1'b0}}));
endmodule

// File: rtl/msi_vector_rx.sv
module msi_vector_rx
  import msi_rx_pkg::*;
#(
  parameter int NUM_VEC = 64,
  parameter int RA_W    = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            msg_valid,
  input  logic [63:0]     msg_addr,
  input  logic [31:0]     msg_data,
  input  logic            reg_we,
  input  logic            reg_re,
  input  logic [RA_W-1:0] reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            irq_out
);
  localparam int NB    = (NUM_VEC + BANK_VEC - 1) / BANK_VEC;
  localparam int HIT_W = NB * BANK_VEC;

  logic [31:0]      tgt_lo_q, tgt_hi_q;
  logic [HIT_W-1:0] hit_vec;
  logic [31:0]      en_all   [NB];
  logic [31:0]      mask_all [NB];
  logic [31:0]      stat_all [NB];
  logic [NB-1:0]    pend_all;
  logic [31:0]      rd_mux;

  msi_msg_decode #(.NUM_VEC(NUM_VEC), .HIT_W(HIT_W)) u_dec (
    .msg_valid (msg_valid),
    .msg_addr  (msg_addr),
    .msg_data  (msg_data),
    .target    ({tgt_hi_q, tgt_lo_q}),
    .hit_vec   (hit_vec)
  );

  // word index -> bank number and register within the bank
  function automatic bank_sel_e sel_of(input logic [RA_W-1:0] a, input int b);
    int w;
    w = int'(a) - BANK_BASE - b * BANK_STRIDE;
    case (w)
      0:       sel_of = SEL_EN;
      1:       sel_of = SEL_MASK;
      2:       sel_of = SEL_STAT;
      default: sel_of = SEL_NONE;
    endcase
  endfunction

  for (genvar b = 0; b < NB; b++) begin : g_bank
    bank_sel_e sel;
    assign sel = sel_of(reg_addr, b);

    msi_bank #(.BW(BANK_VEC)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .set_vec (hit_vec[b*BANK_VEC +: BANK_VEC]),
      .wr_en   (reg_we && sel == SEL_EN),
      .wr_mask (reg_we && sel == SEL_MASK),
      .wr_stat (reg_we && sel == SEL_STAT),
      .wdata   (reg_wdata),
      .en_q    (en_all[b]),
      .mask_q  (mask_all[b]),
      .stat_q  (stat_all[b]),
      .pend    (pend_all[b])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (reg_addr == RA_W'(0)) rd_mux = tgt_lo_q;
    if (reg_addr == RA_W'(1)) rd_mux = tgt_hi_q;
    for (int b = 0; b < NB; b++) begin
      case (sel_of(reg_addr, b))
        SEL_EN:   rd_mux = en_all[b];
        SEL_MASK: rd_mux = mask_all[b];
        SEL_STAT: rd_mux = stat_all[b];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_lo_q  <= '0;
      tgt_hi_q  <= '0;
      reg_rdata <= '0;
      irq_out   <= 1'b0;
    end else begin
      if (reg_we && reg_addr == RA_W'(0)) tgt_lo_q <= reg_wdata;
      if (reg_we && reg_addr == RA_W'(1)) tgt_hi_q <= reg_wdata;
      reg_rdata <= reg_re ? rd_mux : 32'h0;
      irq_out   <= |pend_all;
    end
  end

  assert_single_hit_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));

  assert_range_drop_R5: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_data >= 32'(NUM_VEC)) |-> (hit_vec == '0));

  assert_addr_drop_R4: assert property (@(posedge clk) disable iff (rst)
    (msg_addr != {tgt_hi_q, tgt_lo_q}) |-> (hit_vec == '0));

  assert_irq_level_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_out == $past(|pend_all)));

  assert_rdata_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !reg_re |=> (reg_rdata == 32'h0));
endmodule

// File: tb/msi_vector_rx_bench.sv
module msi_vector_rx_bench;
  localparam int NV = 64;
  localparam int NBK = 2;
  localparam logic [63:0] TGT = 64'hFEE0_1234_ABCD_0040;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        msg_valid = 1'b0;
  logic [63:0] msg_addr = '0;
  logic [31:0] msg_data = '0;
  logic        reg_we = 1'b0;
  logic        reg_re = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_out;

  int checks = 0;
  int fails = 0;
  bit started = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural reference state
  logic [31:0] m_st [NBK];
  logic [31:0] m_mk [NBK];
  logic [31:0] m_en [NBK];
  logic [63:0] m_tgt;
  logic [31:0] m_rdata;
  logic        m_irq;

  always #2 clk = ~clk;

  msi_vector_rx #(.NUM_VEC(NV), .RA_W(8)) u_msi_vector_rx (
    .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_addr(msg_addr),
    .msg_data(msg_data), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out)
  );

  function automatic logic [31:0] m_read(input int a);
    if (a == 0) return m_tgt[31:0];
    if (a == 1) return m_tgt[63:32];
    for (int b = 0; b < NBK; b++) begin
      if (a == 4 + 4*b) return m_en[b];
      if (a == 5 + 4*b) return m_mk[b];
      if (a == 6 + 4*b) return m_st[b];
    end
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    started <= 1;
    if (rst) begin
      for (int b = 0; b < NBK; b++) begin
        m_st[b] = '0; m_mk[b] = '1; m_en[b] = '0;
      end
      m_tgt = '0; m_rdata = '0; m_irq = 0;
    end else begin
      logic [31:0] nrd;
      logic nirq;
      int v;
      nrd = reg_re ? m_read(int'(reg_addr)) : 32'h0;
      nirq = 0;
      for (int b = 0; b < NBK; b++)
        if ((m_st[b] & ~m_mk[b]) != 0) nirq = 1;
      for (int b = 0; b < NBK; b++)
        if (reg_we && int'(reg_addr) == 6 + 4*b) m_st[b] = m_st[b] & ~reg_wdata;
      v = int'(msg_data);
      if (msg_valid && msg_addr == m_tgt && msg_data < 32'(NV))
        if (m_en[v/32][v%32]) m_st[v/32][v%32] = 1'b1;
      if (reg_we) begin
        if (reg_addr == 0) m_tgt[31:0] = reg_wdata;
        if (reg_addr == 1) m_tgt[63:32] = reg_wdata;
        for (int b = 0; b < NBK; b++) begin
          if (int'(reg_addr) == 4 + 4*b) m_en[b] = reg_wdata;
          if (int'(reg_addr) == 5 + 4*b) m_mk[b] = reg_wdata;
        end
      end
      m_rdata = nrd;
      m_irq = nirq;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      checks++;
      if (reg_rdata !== m_rdata) begin
        fails++;
        $display("FAIL %s rdata actual=%h expected=%h", cur_req, reg_rdata, m_rdata);
      end
      checks++;
      if (irq_out !== m_irq) begin
        fails++;
        $display("FAIL %s irq_out actual=%b expected=%b", cur_req, irq_out, m_irq);
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s explicit actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [63:0] a, input int v);
    msg_valid = 1; msg_addr = a; msg_data = 32'(v);
    @(negedge clk);
    msg_valid = 0;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    reg_we = 1; reg_addr = 8'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input int a, input logic [31:0] exp, input string req);
    reg_re = 1; reg_addr = 8'(a);
    @(negedge clk);
    reg_re = 0;
    chk(reg_rdata, exp, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values, still in reset
    chk(32'(irq_out), 0, "R1");
    rst = 0;
    @(negedge clk);
    rd(5, 32'hFFFF_FFFF, "R1");
    rd(4, 32'h0, "R1");
    rd(6, 32'h0, "R1");
    rd(0, 32'h0, "R1");

    cur_req = "R2";
    wr(0, TGT[31:0]);
    wr(1, TGT[63:32]);
    rd(0, TGT[31:0], "R2");
    rd(1, TGT[63:32], "R2");

    cur_req = "R10";
    wr(4, '1); wr(8, '1); wr(5, '0); wr(9, '0);
    rd(8, 32'hFFFF_FFFF, "R10");

    cur_req = "R3";
    send(TGT, 5);
    rd(6, 32'h20, "R3");
    chk(32'(irq_out), 1, "R7");
    cur_req = "R11";
    send(TGT, 40);
    rd(10, 32'h100, "R11");

    cur_req = "R6";
    wr(6, 32'h0);
    rd(6, 32'h20, "R6");
    wr(6, 32'h20);
    wr(10, 32'h100);
    @(negedge clk);
    chk(32'(irq_out), 0, "R7");
    rd(6, 32'h0, "R6");

    cur_req = "R4";
    send(TGT ^ 64'h1_0000_0000, 2);
    send(TGT ^ 64'h4, 2);
    rd(6, 32'h0, "R4");

    cur_req = "R5";
    send(TGT, 64);
    send(TGT, 200);
    wr(4, 32'hFFFF_FFF7);
    send(TGT, 3);
    rd(6, 32'h0, "R5");
    rd(10, 32'h0, "R5");
    chk(32'(irq_out), 0, "R5");

    cur_req = "R8";
    wr(5, 32'h80);
    send(TGT, 7);
    @(negedge clk);
    chk(32'(irq_out), 0, "R8");
    rd(6, 32'h80, "R8");
    wr(5, 32'h0);
    @(negedge clk);
    chk(32'(irq_out), 1, "R8");
    wr(6, 32'h80);

    cur_req = "R9";
    send(TGT, 10);
    msg_valid = 1; msg_addr = TGT; msg_data = 9;
    reg_we = 1; reg_addr = 6; reg_wdata = 32'h600;
    @(negedge clk);
    msg_valid = 0; reg_we = 0;
    rd(6, 32'h200, "R9");

    cur_req = "R10";
    wr(3, 32'hDEAD_BEEF);
    rd(3, 32'h0, "R10");
    rd(12, 32'h0, "R10");
    rd(6, 32'h200, "R10");
    repeat (4) @(negedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule